// File: doc/BRIEF.md
# PWM Dead-Time and Output Conditioning Stage

This block sits between one PWM generator and the pins it drives. It takes the generator's two raw level signals, `raw_a` and `raw_b`. When the complementary mode is selected, it builds a non-overlapping pair from `raw_a` alone:

- The high-side output follows `raw_a`, but only after `raw_a` has stayed high for a programmed number of clocks.
- The low-side output follows the inverse of `raw_a`, but only after `raw_a` has stayed low for a second, independently programmed number of clocks.

When the mode is off, the two raw signals go straight through. After that, each output goes through three steps, in this order:

1. The output-enable mask is applied. A single mask write can switch both outputs at the same moment, which is useful for motor commutation.
2. A fault-forcing step is applied. It takes effect only for outputs whose fault bit is set.
3. A final polarity inversion is applied.

A sticky fault flag records every clock on which the fault input was seen.

All signals are plain levels that are sampled on every clock. There is no data stream, so there is no valid/ready handshake and no back-pressure. Every output is registered, and an input change shows at the pins one clock later.

Top module: `pwmc_out_stage`

## Requirements
- R1: While `rst_n` is low, `pwm_out` is 2'b00 and `fault_irq` is 0.
- R2: With `db_en` = 0, `pwm_out[0]` equals `raw_a` and `pwm_out[1]` equals `raw_b` of the previous clock. This assumes the output is enabled, there is no fault forcing and there is no inversion.
- R3: With `db_en` = 1, `pwm_out[0]` is 1 one clock after a sample of `raw_a` = 1 exactly when `raw_a` was also 1 on each of the `rise_dly` samples before it. It drops one clock after `raw_a` is sampled 0. `rise_dly` is a 10-bit clock count, and values up to 1023 are honoured.
- R4: With `db_en` = 1, `pwm_out[1]` is 1 one clock after a sample of `raw_a` = 0 exactly when `raw_a` was also 0 on each of the `fall_dly` samples before it. In this mode `raw_b` has no effect.
- R5: In dead-time mode, a `raw_a` pulse that lasts no more than `rise_dly` clocks produces no pulse on `pwm_out[0]`.
- R6: In dead-time mode, the two outputs before inversion are never high in the same clock. This holds even when both delays are 0.
- R7: When `fault_in` = 1 and `fault_mask[i]` = 1, output i is at its inactive level one clock later. The inactive level is 0 before inversion. Outputs whose fault bit is clear are unaffected.
- R8: When `out_en[i]` = 0, output i is at its inactive level one clock later.
- R9: `invert[i]` = 1 flips output i after masking and fault forcing. A forced or disabled output therefore reads 1 when its invert bit is set.
- R10: `fault_irq` is 1 on the clock after any sample of `fault_in` = 1, whatever the fault bits are.
- R11: `fault_irq` stays 1 until a clock on which `fault_irq_clr` = 1 and `fault_in` = 0. If both are 1 on the same clock, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raw_a | input | 1 | First raw PWM level from the generator |
| raw_b | input | 1 | Second raw PWM level; ignored in dead-time mode |
| fault_in | input | 1 | Fault input, active high |
| db_en | input | 1 | Selects the complementary dead-time mode |
| rise_dly | input | 10 | Delay in clocks before the high-side output rises |
| fall_dly | input | 10 | Delay in clocks before the low-side output rises |
| out_en | input | 2 | Per-output enable mask |
| fault_mask | input | 2 | Per-output fault-forcing bits |
| invert | input | 2 | Per-output final polarity inversion |
| fault_irq_clr | input | 1 | Write-one-to-clear pulse for the fault flag |
| pwm_out | output | 2 | Conditioned outputs |
| fault_irq | output | 1 | Sticky fault flag |

## Verification
The hardest behaviour to reach from the ports is the saturation edge of the delay counters. With `rise_dly` at 1023, `raw_a` must be held high for more than a thousand clocks without a single low sample before the high-side output may rise. The stimulus therefore includes one deliberately long, uninterrupted high run at the largest delay, then short bursts around the delay value to show that pulses are suppressed. The stimulus also sets both delays to 0 while `raw_a` toggles every clock, to test the non-overlap rule at its tightest. Separately, it drives fault and clear in the same clock to exercise the set-over-clear priority.

// File: rtl/pwmc_pkg.sv
package pwmc_pkg;
  parameter int PWMC_DLY_W = 10;
  parameter int PWMC_NCH   = 2;
  typedef logic [PWMC_NCH-1:0] pwmc_vec_t;
endpackage

// File: rtl/pwmc_edge_delay.sv
// Counts consecutive clocks on which in_lvl was high and raises act only
// once that run has reached the programmed delay.
module pwmc_edge_delay #(
  parameter int DLY_W = pwmc_pkg::PWMC_DLY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_lvl,
  input  logic [DLY_W-1:0] dly,
  output logic             act
);
  localparam logic [DLY_W-1:0] RUN_SAT = '1;

  logic [DLY_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              run_q <= '0;
    else if (!in_lvl)        run_q <= '0;
    else if (run_q != RUN_SAT) run_q <= run_q + 1'b1;
  end

  assign act = in_lvl && (run_q >= dly);

  // R5: a fresh high level with a nonzero delay never activates at once
  // R5
  fresh_run_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(in_lvl) && in_lvl && dly != '0) |-> !act);
endmodule

// File: rtl/pwmc_chan_cond.sv
// One output lane: enable mask, fault forcing, final inversion, register.
module pwmc_chan_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic src,
  input  logic en,
  input  logic flt,
  input  logic flt_sel,
  input  logic inv,
  output logic pin
);
  logic gated;
  logic armed;

  always_comb begin
    gated = src & en;
    if (flt && flt_sel) gated = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin   <= 1'b0;
      armed <= 1'b0;
    end else begin
      pin   <= gated ^ inv;
      armed <= 1'b1;
    end
  end

  // R7
  fault_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(flt) && $past(flt_sel)) |-> (pin == $past(inv)));

  // R8
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(en)) |-> (pin == $past(inv)));
endmodule

// File: rtl/pwmc_out_stage.sv
module pwmc_out_stage #(
  parameter int DLY_W = pwmc_pkg::PWMC_DLY_W,
  parameter int NCH   = pwmc_pkg::PWMC_NCH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raw_a,
  input  logic             raw_b,
  input  logic             fault_in,
  input  logic             db_en,
  input  logic [DLY_W-1:0] rise_dly,
  input  logic [DLY_W-1:0] fall_dly,
  input  logic [NCH-1:0]   out_en,
  input  logic [NCH-1:0]   fault_mask,
  input  logic [NCH-1:0]   invert,
  input  logic             fault_irq_clr,
  output logic [NCH-1:0]   pwm_out,
  output logic             fault_irq
);
  logic hi_act, lo_act;
  logic [NCH-1:0] raw_vec, db_vec, src_vec;

  pwmc_edge_delay #(.DLY_W(DLY_W)) u_dly_hi (
    .clk(clk), .rst_n(rst_n), .in_lvl(raw_a), .dly(rise_dly), .act(hi_act));

  pwmc_edge_delay #(.DLY_W(DLY_W)) u_dly_lo (
    .clk(clk), .rst_n(rst_n), .in_lvl(~raw_a), .dly(fall_dly), .act(lo_act));

  always_comb begin
    raw_vec    = '0;
    db_vec     = '0;
    raw_vec[0] = raw_a;
    raw_vec[1] = raw_b;
    db_vec[0]  = hi_act;
    db_vec[1]  = lo_act;
    src_vec    = db_en ? db_vec : raw_vec;
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_lane
    pwmc_chan_cond u_lane (
      .clk(clk), .rst_n(rst_n), .src(src_vec[ch]), .en(out_en[ch]),
      .flt(fault_in), .flt_sel(fault_mask[ch]), .inv(invert[ch]),
      .pin(pwm_out[ch]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) fault_irq <= 1'b0;
    else        fault_irq <= fault_in | (fault_irq & ~fault_irq_clr);
  end

  // R6
  pair_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_act && lo_act));

  // R10
  fault_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(fault_in)) |-> fault_irq);

  // R11
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(fault_irq) && !$past(fault_irq_clr)) |-> fault_irq);
endmodule

// File: tb/pwmc_out_stage_tb.sv
`timescale 1ns/1ps
module pwmc_out_stage_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, raw_a, raw_b, fault_in, db_en, fault_irq_clr;
  logic [9:0] rise_dly, fall_dly;
  logic [1:0] out_en, fault_mask, invert, pwm_out;
  logic       fault_irq;

  pwmc_out_stage u_dut (
    .clk(clk), .rst_n(rst_n), .raw_a(raw_a), .raw_b(raw_b),
    .fault_in(fault_in), .db_en(db_en), .rise_dly(rise_dly),
    .fall_dly(fall_dly), .out_en(out_en), .fault_mask(fault_mask),
    .invert(invert), .fault_irq_clr(fault_irq_clr),
    .pwm_out(pwm_out), .fault_irq(fault_irq));

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;
  string phase  = "R1";

  // behavioural reference
  int         hi_run, lo_run;
  logic [1:0] exp_out, src;
  logic       exp_irq, m_hi, m_lo;

  always @(posedge clk) begin
    if (!rst_n) begin
      hi_run = 0; lo_run = 0; exp_out = 2'b00; exp_irq = 1'b0;
    end else begin
      m_hi = raw_a && (hi_run >= int'(rise_dly));
      m_lo = !raw_a && (lo_run >= int'(fall_dly));
      src  = db_en ? {m_lo, m_hi} : {raw_b, raw_a};
      for (int ch = 0; ch < 2; ch++)
        exp_out[ch] = (src[ch] && out_en[ch] && !(fault_in && fault_mask[ch])) ^ invert[ch];
      exp_irq = fault_in || (exp_irq && !fault_irq_clr);
      hi_run = raw_a ? ((hi_run < 1023) ? hi_run + 1 : 1023) : 0;
      lo_run = !raw_a ? ((lo_run < 1023) ? lo_run + 1 : 1023) : 0;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      for (int ch = 0; ch < 2; ch++) begin
        checks++;
        if (pwm_out[ch] !== exp_out[ch]) begin
          fails++;
          $display("FAIL %s pwm_out[%0d] actual %b expected %b", phase, ch, pwm_out[ch], exp_out[ch]);
        end
      end
      checks++;
      if (fault_irq !== exp_irq) begin
        fails++;
        $display("FAIL %s fault_irq actual %b expected %b",
                 (phase == "R11") ? "R11" : (phase == "R1" ? "R1" : "R10"), fault_irq, exp_irq);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic runs(int n, int maxlen);
    for (int i = 0; i < n; i++) begin
      raw_a = ~raw_a;
      for (int k = 0; k <= int'($urandom % maxlen); k++) begin
        raw_b = 1'($urandom % 2);
        tick(1);
      end
    end
  endtask

  initial begin
    rst_n = 0; raw_a = 0; raw_b = 0; fault_in = 0; db_en = 0; fault_irq_clr = 0;
    rise_dly = 0; fall_dly = 0; out_en = 2'b11; fault_mask = 0; invert = 0;
    tick(4);                            // R1 checked while in reset
    rst_n = 1;

    phase = "R2"; db_en = 0;
    for (int i = 0; i < 200; i++) begin
      raw_a = 1'($urandom % 2); raw_b = 1'($urandom % 2); tick(1);
    end

    phase = "R3"; db_en = 1; rise_dly = 3; fall_dly = 5;
    runs(60, 10);
    rise_dly = 10'd1023; raw_a = 1; tick(1100); raw_a = 0; tick(20);
    raw_a = 1; tick(1023); raw_a = 0; tick(5);

    phase = "R4"; rise_dly = 0; fall_dly = 7;
    runs(60, 12);

    phase = "R5"; rise_dly = 4; fall_dly = 4;
    for (int len = 1; len <= 6; len++) begin
      raw_a = 1; tick(len); raw_a = 0; tick(10);
    end

    phase = "R6"; rise_dly = 0; fall_dly = 0;
    for (int i = 0; i < 100; i++) begin
      raw_a = ~raw_a; raw_b = 1'($urandom % 2); tick(1);
    end

    phase = "R7"; rise_dly = 2; fall_dly = 2;
    for (int m = 0; m < 4; m++) begin
      fault_mask = 2'(m);
      for (int i = 0; i < 40; i++) begin
        db_en = 1'($urandom % 2); raw_a = 1'($urandom % 2); raw_b = 1'($urandom % 2);
        fault_in = 1'($urandom % 2); tick(1);
      end
    end
    fault_in = 0; fault_irq_clr = 1; tick(1); fault_irq_clr = 0; fault_mask = 0;

    phase = "R8";
    for (int m = 0; m < 4; m++) begin
      out_en = 2'(m);
      for (int i = 0; i < 30; i++) begin
        db_en = 1'($urandom % 2); raw_a = 1'($urandom % 2); raw_b = 1'($urandom % 2); tick(1);
      end
    end

    phase = "R9";
    for (int v = 0; v < 4; v++) begin
      invert = 2'(v);
      for (int i = 0; i < 30; i++) begin
        out_en = 2'($urandom % 4); fault_mask = 2'($urandom % 4);
        fault_in = 1'($urandom % 2); raw_a = 1'($urandom % 2); raw_b = 1'($urandom % 2);
        tick(1);
      end
    end
    fault_in = 0; invert = 0; out_en = 2'b11; fault_mask = 0;
    fault_irq_clr = 1; tick(1); fault_irq_clr = 0;

    phase = "R10";
    tick(3); fault_in = 1; tick(1); fault_in = 0; tick(6);

    phase = "R11";
    fault_irq_clr = 1; tick(1); fault_irq_clr = 0; tick(3);
    fault_in = 1; fault_irq_clr = 1; tick(1); fault_in = 0; fault_irq_clr = 0; tick(3);
    for (int i = 0; i < 100; i++) begin
      fault_in = (($urandom % 5) == 0); fault_irq_clr = 1'($urandom % 2); tick(1);
    end
    fault_in = 0; fault_irq_clr = 0; tick(2);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired in phase %s", phase);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule